// File: doc/BRIEF.md
# Clock Stop and Power-Down Sequencer

This block sits between the clock dividers and the output drivers of a clock generator. When the asynchronous power-down request `pd` goes high, it parks every stoppable output at a defined level. It releases them again without glitches once the request is withdrawn and a restart delay has run.

All logic runs on the reference clock `clk`. Each output clock reaches the block as a level that a divider clocked by `clk` produces, so every source holds each level for at least one `clk` cycle. Single-ended outputs park low. A differential pair arrives as its complement waveform and parks with true high. Its complement is always floated, and its true side is either driven or floated, as chosen per pair.

The sequencer has four states:
- **RUN**: outputs are free.
- **ARM**: the request has been seen on one rising edge of the qualifying complement clock (`dif_src_c[0]`).
- **PARK**: the stop request is active.
- **WAKE**: the request is gone and the restart counter runs.

Transitions:
- **RUN→ARM**: the synchronised request is high on a qualifying rising edge.
- **ARM→RUN**: the request drops before the next qualifying edge.
- **ARM→PARK**: the request is still high on the next qualifying rising edge.
- **PARK→WAKE**: the request drops. The counter clears.
- **WAKE→PARK**: the request returns.
- **WAKE→RUN**: the counter reaches `STABLE_CYC`-1.

Top module: `clk_stop_seq`

## Requirements
- R1: `pd` passes through a two-flop synchroniser. Stopping starts only after the synchronised request has been high on two consecutive rising edges of `dif_src_c[0]`.
- R2: While the stop request is active, a stoppable single-ended output is forced low from the cycle after its source is sampled going 1→0, and stays low.
- R3: A stoppable pair parks from the cycle after its complement source is sampled going 1→0. Once parked, `dif_t_out`=1 and `dif_c_oe`=0, and `dif_t_oe`=1 when its `dif_hiz` bit is 0.
- R4: With its `dif_hiz` bit at 1, a parked pair has `dif_t_oe`=0 and `dif_c_oe`=0 while in PARK and during the first `DRIVE_CYC` cycles of WAKE.
- R5: An output whose stop-enable bit is 0 never parks and keeps following its source.
- R6: Outputs leave the parked state only at a sampled 1→0 of their source after the stop request has ended. The first high pulse after release therefore has full width.
- R7: In WAKE, once the counter reaches `DRIVE_CYC`, every parked pair drives its true output high (`dif_t_oe`=1).
- R8: The stop request ends exactly `STABLE_CYC` cycles after WAKE is entered. A request that returns during WAKE sends the block back to PARK with no release.
- R9: After reset the block is in RUN. All enables are 1, and outputs follow their sources: `se_out`=`se_src`, `dif_t_out`=~`dif_src_c`, `dif_c_out`=`dif_src_c`.
- R10: A request that drops before the second qualifying edge causes no output to park.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pd | input | 1 | Asynchronous power-down request, active high |
| se_src | input | N_SE | Single-ended source clocks |
| se_stop_en | input | N_SE | 1 = single-ended output stoppable |
| dif_src_c | input | N_DIF | Complement source of each pair; bit 0 also qualifies the request |
| dif_stop_en | input | N_DIF | 1 = pair stoppable |
| dif_hiz | input | N_DIF | Parked pair: 0 = true driven high, 1 = both floated |
| se_out | output | N_SE | Gated single-ended clocks |
| dif_t_out | output | N_DIF | Gated true outputs |
| dif_c_out | output | N_DIF | Gated complement outputs |
| dif_t_oe | output | N_DIF | True output enable |
| dif_c_oe | output | N_DIF | Complement output enable |

## Verification
The assertions assume that each source clock holds a level for at least one `clk` cycle, so that every 1→0 step is sampled. They also assume that the stop-enable and float-select bits stay still while a stop is pending. The stimulus builds every source from a `clk`-based toggle counter with half-periods of one to three cycles. It sets the control bits only during reset and changes `pd` away from clock edges.

// File: rtl/cs_pkg.sv
package cs_pkg;
    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_ARM  = 2'd1,
        ST_PARK = 2'd2,
        ST_WAKE = 2'd3
    } cs_state_e;
endpackage

// File: rtl/cs_sync.sv
module cs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/cs_ctrl.sv
module cs_ctrl
    import cs_pkg::*;
#(
    parameter int STABLE_CYC = 25772,
    parameter int DRIVE_CYC  = 4295
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd_s,
    input  logic ref_c,
    output logic stop_req,
    output logic hiz_ok
);
    localparam int CW = $clog2(STABLE_CYC + 1);

    cs_state_e       state, nxt;
    logic [CW-1:0]   cnt, cnt_nxt;
    logic            ref_q;
    logic            ref_rise;

    assign ref_rise = ref_c & ~ref_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_RUN;
            cnt   <= '0;
            ref_q <= 1'b0;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
            ref_q <= ref_c;
        end
    end

    always_comb begin
        nxt     = state;
        cnt_nxt = cnt;
        unique case (state)
            ST_RUN:  if (pd_s && ref_rise) nxt = ST_ARM;
            ST_ARM: begin
                if (!pd_s)         nxt = ST_RUN;
                else if (ref_rise) nxt = ST_PARK;
            end
            ST_PARK: begin
                if (!pd_s) begin
                    nxt     = ST_WAKE;
                    cnt_nxt = '0;
                end
            end
            ST_WAKE: begin
                if (pd_s)                            nxt = ST_PARK;
                else if (cnt == CW'(STABLE_CYC - 1)) nxt = ST_RUN;
                else                                 cnt_nxt = cnt + 1'b1;
            end
        endcase
    end

    always_comb begin
        stop_req = (state == ST_PARK) || (state == ST_WAKE);
        hiz_ok   = (state == ST_PARK) ||
                   ((state == ST_WAKE) && (cnt < CW'(DRIVE_CYC)));
    end

    // R1: the stop request starts only on a qualifying edge with the request present
    p_qualified_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_req) |-> $past(pd_s && ref_rise));

    // R8: the stop request ends only when the restart count completes
    p_release_time_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stop_req) |-> $past(cnt == CW'(STABLE_CYC - 1)));

    // R8: the counter never runs past its limit
    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CW'(STABLE_CYC));
endmodule

// File: rtl/cs_se_lane.sv
module cs_se_lane (
    input  logic clk,
    input  logic rst_n,
    input  logic src,
    input  logic stop_en,
    input  logic stop_req,
    output logic out
);
    logic src_q, parked, fall;

    assign fall = src_q & ~src;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q  <= 1'b0;
            parked <= 1'b0;
        end else begin
            src_q <= src;
            if (!parked) begin
                if (stop_req && stop_en && fall) parked <= 1'b1;
            end else if (!stop_req && fall) begin
                parked <= 1'b0;
            end
        end
    end

    assign out = src & ~parked;

    // R2: parking begins only at a falling edge under an active request
    p_park_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(parked) |-> $past(stop_req && stop_en && src_q && !src));

    // R5: a free-running output never parks
    p_free_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop_en && !parked) |=> !parked);

    // R6: release only at a falling edge once the request has ended
    p_clean_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(parked) |-> $past(!stop_req && src_q && !src));
endmodule

// File: rtl/cs_diff_lane.sv
module cs_diff_lane (
    input  logic clk,
    input  logic rst_n,
    input  logic src_c,
    input  logic stop_en,
    input  logic hiz_sel,
    input  logic stop_req,
    input  logic hiz_ok,
    output logic t_out,
    output logic c_out,
    output logic t_oe,
    output logic c_oe
);
    logic c_q, parked, fall;

    assign fall = c_q & ~src_c;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q    <= 1'b0;
            parked <= 1'b0;
        end else begin
            c_q <= src_c;
            if (!parked) begin
                if (stop_req && stop_en && fall) parked <= 1'b1;
            end else if (!stop_req && fall) begin
                parked <= 1'b0;
            end
        end
    end

    always_comb begin
        t_out = parked ? 1'b1 : ~src_c;
        c_out = parked ? 1'b0 : src_c;
        t_oe  = !parked || !(hiz_sel && hiz_ok);
        c_oe  = !parked;
    end

    // R3: a pair parks only on a falling complement edge
    p_park_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(parked) |-> $past(stop_req && stop_en && c_q && !src_c));

    // R3: a driven parked pair holds true high
    p_true_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!c_oe && t_oe) |-> t_out);

    // R4: a floated true output implies a floated complement
    p_both_float_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !t_oe |-> !c_oe);

    // R6: release only at a falling complement edge after the request ends
    p_clean_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(parked) |-> $past(!stop_req && c_q && !src_c));
endmodule

// File: rtl/clk_stop_seq.sv
module clk_stop_seq #(
    parameter int N_SE       = 4,
    parameter int N_DIF      = 4,
    parameter int STABLE_CYC = 25772,
    parameter int DRIVE_CYC  = 4295
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pd,
    input  logic [N_SE-1:0]  se_src,
    input  logic [N_SE-1:0]  se_stop_en,
    input  logic [N_DIF-1:0] dif_src_c,
    input  logic [N_DIF-1:0] dif_stop_en,
    input  logic [N_DIF-1:0] dif_hiz,
    output logic [N_SE-1:0]  se_out,
    output logic [N_DIF-1:0] dif_t_out,
    output logic [N_DIF-1:0] dif_c_out,
    output logic [N_DIF-1:0] dif_t_oe,
    output logic [N_DIF-1:0] dif_c_oe
);
    logic pd_s, stop_req, hiz_ok;

    cs_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pd), .q(pd_s)
    );

    cs_ctrl #(.STABLE_CYC(STABLE_CYC), .DRIVE_CYC(DRIVE_CYC)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .pd_s(pd_s), .ref_c(dif_src_c[0]),
        .stop_req(stop_req), .hiz_ok(hiz_ok)
    );

    for (genvar i = 0; i < N_SE; i++) begin : g_se
        cs_se_lane u_lane (
            .clk(clk), .rst_n(rst_n), .src(se_src[i]),
            .stop_en(se_stop_en[i]), .stop_req(stop_req), .out(se_out[i])
        );
    end

    for (genvar j = 0; j < N_DIF; j++) begin : g_dif
        cs_diff_lane u_lane (
            .clk(clk), .rst_n(rst_n), .src_c(dif_src_c[j]),
            .stop_en(dif_stop_en[j]), .hiz_sel(dif_hiz[j]),
            .stop_req(stop_req), .hiz_ok(hiz_ok),
            .t_out(dif_t_out[j]), .c_out(dif_c_out[j]),
            .t_oe(dif_t_oe[j]), .c_oe(dif_c_oe[j])
        );
    end
endmodule

// File: tb/clk_stop_seq_test.sv
module clk_stop_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 2;
    localparam int ND = 2;
    localparam int STABLE = 40;
    localparam int DRIVE = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pd = 1'b0;
    logic [NS-1:0] se_src = '0, se_en = 2'b01;
    logic [ND-1:0] dc = '0, d_en = 2'b11, d_hiz = 2'b10;
    logic [NS-1:0] se_out;
    logic [ND-1:0] t_out, c_out, t_oe, c_oe;

    int n_chk = 0, n_bad = 0, tick = 0;
    bit done = 0;

    clk_stop_seq #(.N_SE(NS), .N_DIF(ND), .STABLE_CYC(STABLE), .DRIVE_CYC(DRIVE)) uut (
        .clk(clk), .rst_n(rst_n), .pd(pd), .se_src(se_src), .se_stop_en(se_en),
        .dif_src_c(dc), .dif_stop_en(d_en), .dif_hiz(d_hiz),
        .se_out(se_out), .dif_t_out(t_out), .dif_c_out(c_out),
        .dif_t_oe(t_oe), .dif_c_oe(c_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // source clocks change on the clock edge like divider flops
    always @(posedge clk) begin
        tick <= tick + 1;
        if (tick % 2 == 0) se_src[0] <= ~se_src[0];
        if (tick % 3 == 0) se_src[1] <= ~se_src[1];
        if (tick % 2 == 1) dc[0] <= ~dc[0];
        dc[1] <= ~dc[1];
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int m_ph, m_cnt;
    bit m_s1, m_s2, m_ref;
    bit m_sp[NS], m_sprev[NS], m_dp[ND], m_dprev[ND];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ph = 0; m_cnt = 0; m_s1 = 0; m_s2 = 0; m_ref = 0;
            foreach (m_sp[i]) begin m_sp[i] = 0; m_sprev[i] = 0; end
            foreach (m_dp[i]) begin m_dp[i] = 0; m_dprev[i] = 0; end
        end else begin
            bit stopping, rr, f;
            stopping = (m_ph >= 2);
            rr = dc[0] && !m_ref;
            foreach (m_sp[i]) begin
                f = m_sprev[i] && !se_src[i];
                if (f && !m_sp[i] && stopping && se_en[i]) m_sp[i] = 1;
                else if (f && m_sp[i] && !stopping) m_sp[i] = 0;
                m_sprev[i] = se_src[i];
            end
            foreach (m_dp[i]) begin
                f = m_dprev[i] && !dc[i];
                if (f && !m_dp[i] && stopping && d_en[i]) m_dp[i] = 1;
                else if (f && m_dp[i] && !stopping) m_dp[i] = 0;
                m_dprev[i] = dc[i];
            end
            if (m_ph == 0 && m_s2 && rr) m_ph = 1;
            else if (m_ph == 1) m_ph = !m_s2 ? 0 : (rr ? 2 : 1);
            else if (m_ph == 2 && !m_s2) begin m_ph = 3; m_cnt = 0; end
            else if (m_ph == 3) begin
                if (m_s2) m_ph = 2;
                else if (m_cnt == STABLE - 1) m_ph = 0;
                else m_cnt++;
            end
            m_ref = dc[0];
            m_s2 = m_s1;
            m_s1 = pd;
        end
    end

    // compare with the model every cycle, away from the active edge
    int hi_run = 0;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit hz_ok;
            hz_ok = (m_ph == 2) || (m_ph == 3 && m_cnt < DRIVE);
            for (int i = 0; i < NS; i++)
                check("R2 model se_out", 32'(se_out[i]), 32'(se_src[i] & !m_sp[i]));
            for (int i = 0; i < ND; i++) begin
                check("R3 model t_out", 32'(t_out[i]), 32'(m_dp[i] ? 1'b1 : !dc[i]));
                check("R3 model c_out", 32'(c_out[i]), 32'(m_dp[i] ? 1'b0 : dc[i]));
                check("R4 model t_oe", 32'(t_oe[i]), 32'(!m_dp[i] || !(d_hiz[i] && hz_ok)));
                check("R3 model c_oe", 32'(c_oe[i]), 32'(!m_dp[i]));
            end
            // R6: every completed high pulse of se_out[0] is full width
            if (se_out[0]) hi_run++;
            else if (hi_run != 0) begin
                check("R6 pulse width", 32'(hi_run), 32'd2);
                hi_run = 0;
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int n, toggles;
        logic prev;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R9 reset t_oe", 32'(t_oe), 32'h3);
        check("R9 reset c_oe", 32'(c_oe), 32'h3);
        check("R9 reset follow", 32'(c_out), 32'(dc));
        repeat (20) @(negedge clk);

        // R10: short request, at most one qualifying edge
        pd = 1'b1;
        repeat (3) @(negedge clk);
        pd = 1'b0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            check("R10 no park c_oe", 32'(c_oe), 32'h3);
        end
        repeat (10) @(negedge clk);

        // R1: full request, measure latency to park
        pd = 1'b1;
        n = 0;
        while (c_oe[0] && n < 40) begin @(negedge clk); n++; end
        check("R1 latency in range", 32'(n >= 6 && n <= 16), 32'd1);
        repeat (20) @(negedge clk);
        check("R2 se parked low", 32'(se_out[0]), 32'd0);
        check("R3 true driven high", 32'({t_out[0], t_oe[0], c_oe[0]}), 32'b110);
        check("R4 both floated", 32'({t_oe[1], c_oe[1]}), 32'b00);
        toggles = 0;
        prev = se_out[1];
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (se_out[1] != prev) toggles++;
            prev = se_out[1];
            check("R5 free follows", 32'(se_out[1]), 32'(se_src[1]));
        end
        check("R5 free toggles", 32'(toggles > 0), 32'd1);

        // R7: redrive after DRIVE cycles of WAKE
        pd = 1'b0;
        repeat (6) @(negedge clk);
        check("R7 still floated", 32'(t_oe[1]), 32'd0);
        repeat (14) @(negedge clk);
        check("R7 redriven", 32'({t_oe[1], t_out[1], c_oe[1]}), 32'b110);

        // R8: request returns during WAKE
        pd = 1'b1;
        repeat (60) @(negedge clk);
        check("R8 repark held", 32'(c_oe), 32'h0);
        check("R8 se held", 32'(se_out[0]), 32'd0);
        pd = 1'b0;
        repeat (30) @(negedge clk);
        check("R8 wait incomplete", 32'(c_oe), 32'h0);
        repeat (30) @(negedge clk);
        check("R6 released c_oe", 32'(c_oe), 32'h3);
        check("R9 released t_oe", 32'(t_oe), 32'h3);
        repeat (20) @(negedge clk);
        check("R9 follow again", 32'(se_out), 32'(se_src));

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule